// File: doc/BRIEF.md
# Power-On Bus Program Loader

This block fills the CPU's RAM with a program before the CPU runs its first instruction. At power-on it holds the microcode ROM disabled and takes over the CPU's shared data bus and the two RAM-path strobes: MAR load and RAM write. Program bytes arrive one at a time on a valid/ready input. For each byte the loader spends one CPU clock cycle driving the target address onto the bus with the MAR strobe raised. It spends the next cycle driving the byte itself with the RAM-write strobe raised. Addresses run upward from zero.

The loader keeps in step with the CPU clock. It detects that clock's falling edge in its own fast clock domain and changes its outputs only there, so every value is settled when the CPU's registers sample on the rising edge. The final byte is the one marked `in_last`, or the byte written to the highest address. After it, the loader releases the bus and both strobes to high impedance for one CPU cycle. It then enables the microcode ROM and raises a one-cycle step reset, so the CPU starts at microstep 0. Finally it raises `done`. From then on it accepts no more input until the next reset.

The high-impedance state is shown as drive-enable outputs. `bus_drive` enables the bus drivers and `ctl_drive` enables the MAR and RAM strobe drivers. The chip-level pads combine each enable with its data.

Top module: `bus_loader`

## Requirements
- R1: During and straight after reset, `rom_ce_n`=1, `ctl_drive`=1, `bus_drive`=0, `mar_in`=0, `ram_in`=0, `step_reset`=0, `done`=0 and `in_ready`=1.
- R2: Every output toggles only in response to a falling edge of `cpu_clk`. Outputs hold steady throughout each high phase of `cpu_clk`.
- R3: When a byte is accepted, the next CPU cycle is an address phase: `bus_drive`=1, `mar_in`=1, `ram_in`=0, and `bus_data` carries the address.
- R4: The CPU cycle right after an address phase is a data phase: `bus_drive`=1, `ram_in`=1, `mar_in`=0, and `bus_data` carries the accepted byte.
- R5: The first byte after reset goes to address 0. Each later byte goes to the previous address plus one.
- R6: `mar_in` and `ram_in` are never both 1. Whenever either is 1, both `bus_drive` and `ctl_drive` are 1.
- R7: Loading ends after the data phase of a byte accepted with `in_last`=1, or of the byte written to address 255. The next CPU cycle has `bus_drive`=0, `ctl_drive`=0 and `rom_ce_n`=1.
- R8: The CPU cycle after the release has `rom_ce_n`=0 and `step_reset`=1. `step_reset` lasts exactly one CPU cycle. `rom_ce_n` is never 0 while `ctl_drive` or `bus_drive` is 1.
- R9: `done` rises in the CPU cycle after the step reset and stays 1 until reset. While `done` is 1, `in_ready` is 0, and input activity writes no address or data.
- R10: Only one byte is held at a time. `in_ready` falls in the fast clock cycle after a byte is accepted and stays 0 until that byte's data phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast block clock; `cpu_clk` is sampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_clk | input | 1 | CPU clock, observed only |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Program byte |
| in_last | input | 1 | Marks the final program byte |
| in_ready | output | 1 | Loader can take a byte |
| bus_data | output | 8 | Value for the shared data bus |
| bus_drive | output | 1 | Bus driver enable (0 = high impedance) |
| mar_in | output | 1 | MAR load strobe |
| ram_in | output | 1 | RAM write strobe |
| ctl_drive | output | 1 | Enable for the MAR and RAM strobe drivers (0 = high impedance) |
| rom_ce_n | output | 1 | Microcode ROM chip enable, active low |
| step_reset | output | 1 | Microstep counter reset request |
| done | output | 1 | Handover complete |

## Verification
With the default two-stage synchronizer, the outputs move 2.5 fast cycles after a falling edge of `cpu_clk`. That is long before the next rising edge, so every bus, strobe and handover result is checked at the rising edge of `cpu_clk` that follows the falling edge which caused it. A behavioural MAR and RAM in the bench sample at that same edge, and the checks confirm the phase order: address, data, release, step reset, done. Outputs are sampled at each rising edge and compared again at the following falling edge, before any change can take effect, which checks R2. The handshake response `in_ready` is due one fast cycle after acceptance and is sampled at the next falling edge of `clk`.

// File: rtl/loader_pkg.sv
// Shared types for the bus program loader.
package loader_pkg;
    // Loader sequence: idle/wait, address phase, data phase, release, handover, finished.
    typedef enum logic [2:0] {
        LD_WAIT     = 3'd0,
        LD_ADDR     = 3'd1,
        LD_DATA     = 3'd2,
        LD_RELEASE  = 3'd3,
        LD_HANDOVER = 3'd4,
        LD_DONE     = 3'd5
    } ld_state_t;
endpackage

// File: rtl/loader_edge.sv
// Synchronizes the observed CPU clock into clk and flags each falling edge.
// Assumes cpu_clk is much slower than clk (at least several clk cycles per phase).
module loader_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_clk_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // First synchronizer stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= cpu_clk_i;
    end

    // Remaining synchronizer stages.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/loader_addr.sv
// Target address counter: starts at zero, steps by one per written byte.
// Assumes inc_i is raised for one clk per completed data phase.
module loader_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_max_o
);
    // Count written bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_o <= '0;
        else if (inc_i) addr_o <= addr_o + 1'b1;
    end

    assign at_max_o = &addr_o;

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(addr_o));
endmodule

// File: rtl/loader_seq.sv
// Loader sequencer: holds one input byte and steps through the phases,
// advancing only on CPU clock falling edges.
// Assumes fall_o from loader_edge is a one-clk pulse.
module loader_seq
    import loader_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_last_i,
    input  logic              at_max_i,
    output logic              in_ready_o,
    output ld_state_t         state_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              inc_o
);
    ld_state_t         state_q, state_d;
    logic              have_q;
    logic              last_q;
    logic              finish;
    logic              accept;

    assign in_ready_o = (state_q == LD_WAIT) && !have_q;
    assign accept     = in_valid_i && in_ready_o;
    assign finish     = last_q || at_max_i;
    assign inc_o      = fall_i && (state_q == LD_DATA);

    // Next phase, taken only at a CPU clock falling edge.
    always_comb begin
        state_d = state_q;
        if (fall_i) begin
            unique case (state_q)
                LD_WAIT:     if (have_q) state_d = LD_ADDR;
                LD_ADDR:     state_d = LD_DATA;
                LD_DATA:     state_d = finish ? LD_RELEASE : LD_WAIT;
                LD_RELEASE:  state_d = LD_HANDOVER;
                LD_HANDOVER: state_d = LD_DONE;
                default:     state_d = LD_DONE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_WAIT;
        else        state_q <= state_d;
    end

    // One-byte holding buffer, freed when its data phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            last_q <= 1'b0;
            byte_o <= '0;
        end else if (accept) begin
            have_q <= 1'b1;
            last_q <= in_last_i;
            byte_o <= in_data_i;
        end else if (inc_o) begin
            have_q <= 1'b0;
        end
    end

    assign state_o = state_q;

    a_r2_state_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> state_q == $past(state_q));
    a_r4_data_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && state_q == LD_ADDR) |=> state_q == LD_DATA);
    a_r7_release_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_o && finish) |=> state_q == LD_RELEASE);
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LD_DONE |=> state_q == LD_DONE);
    a_r10_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready_o);
endmodule

// File: rtl/loader_drive.sv
// Decodes the loader phase into bus, strobe, ROM-enable and handover outputs.
// Purely combinational; inherits the falling-edge timing of the phase register.
module loader_drive
    import loader_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  ld_state_t         state_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_drive_o,
    output logic              mar_in_o,
    output logic              ram_in_o,
    output logic              ctl_drive_o,
    output logic              rom_ce_n_o,
    output logic              step_reset_o,
    output logic              done_o
);
    // Output decode per phase.
    always_comb begin
        bus_data_o   = '0;
        bus_drive_o  = 1'b0;
        mar_in_o     = 1'b0;
        ram_in_o     = 1'b0;
        ctl_drive_o  = 1'b1;
        rom_ce_n_o   = 1'b1;
        step_reset_o = 1'b0;
        done_o       = 1'b0;
        unique case (state_i)
            LD_WAIT: ;
            LD_ADDR: begin
                bus_data_o  = DATA_W'(addr_i);
                bus_drive_o = 1'b1;
                mar_in_o    = 1'b1;
            end
            LD_DATA: begin
                bus_data_o  = byte_i;
                bus_drive_o = 1'b1;
                ram_in_o    = 1'b1;
            end
            LD_RELEASE: ctl_drive_o = 1'b0;
            LD_HANDOVER: begin
                ctl_drive_o  = 1'b0;
                rom_ce_n_o   = 1'b0;
                step_reset_o = 1'b1;
            end
            default: begin
                ctl_drive_o = 1'b0;
                rom_ce_n_o  = 1'b0;
                done_o      = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bus_loader.sv
// Power-on program loader: takes bytes from a valid/ready input, writes them
// over the CPU bus via MAR and RAM strobes, then releases the lines and
// hands control to the microcode with a step reset.
// Assumes cpu_clk phases last several clk cycles.
module bus_loader
    import loader_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_clk,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_drive,
    output logic              mar_in,
    output logic              ram_in,
    output logic              ctl_drive,
    output logic              rom_ce_n,
    output logic              step_reset,
    output logic              done
);
    logic              cpu_fall;
    logic              addr_inc;
    logic              addr_max;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] held_byte;
    ld_state_t         state;

    loader_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .cpu_clk_i(cpu_clk), .fall_o(cpu_fall)
    );

    loader_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .inc_i(addr_inc),
        .addr_o(addr), .at_max_o(addr_max)
    );

    loader_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .fall_i(cpu_fall),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
        .at_max_i(addr_max), .in_ready_o(in_ready), .state_o(state),
        .byte_o(held_byte), .inc_o(addr_inc)
    );

    loader_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state_i(state), .addr_i(addr), .byte_i(held_byte),
        .bus_data_o(bus_data), .bus_drive_o(bus_drive),
        .mar_in_o(mar_in), .ram_in_o(ram_in), .ctl_drive_o(ctl_drive),
        .rom_ce_n_o(rom_ce_n), .step_reset_o(step_reset), .done_o(done)
    );

    a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mar_in && ram_in));
    a_r6_strobe_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (mar_in || ram_in) |-> (bus_drive && ctl_drive));
    a_r8_rom_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce_n |-> (!ctl_drive && !bus_drive));
    a_r8_sr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (step_reset && cpu_fall) |=> !step_reset);
    a_r9_no_input_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);
endmodule

// File: tb/bus_loader_test.sv
`timescale 1ns/1ps
module bus_loader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_clk = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready, bus_drive, mar_in, ram_in, ctl_drive, rom_ce_n, step_reset, done;
    logic [7:0] bus_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    // CPU clock: toggles every 8 fast cycles, on falling edges of clk.
    int div = 0;
    always @(negedge clk) begin
        div <= (div == 7) ? 0 : div + 1;
        if (div == 7) cpu_clk <= ~cpu_clk;
    end

    bus_loader uut (
        .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .bus_data(bus_data), .bus_drive(bus_drive),
        .mar_in(mar_in), .ram_in(ram_in), .ctl_drive(ctl_drive),
        .rom_ce_n(rom_ce_n), .step_reset(step_reset), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stimulus table: bit 8 = last flag, bits 7:0 = program byte.
    localparam int NV = 6;
    localparam logic [8:0] VEC [NV] = '{9'h0A5, 9'h03C, 9'h0FF, 9'h000, 9'h07E, 9'h181};

    // Behavioural MAR/RAM and sequence monitor.
    logic [7:0] mar_model;
    logic [7:0] ram_model [256];
    int mar_cnt, ram_cnt, sr_cnt, exp_addr, exp_len, rel_stage;
    bit prev_mar;
    logic [11:0] snap;

    always @(posedge cpu_clk) begin
        if (rst_n) begin
            snap = {bus_data, bus_drive, mar_in, ram_in, ctl_drive};
            if (rel_stage == 1) begin
                check(!ctl_drive && !bus_drive && rom_ce_n && !step_reset, "R7 release",
                      {ctl_drive, bus_drive, rom_ce_n, step_reset}, 4'b0010);
                rel_stage = 2;
            end else if (rel_stage == 2) begin
                check(step_reset && !rom_ce_n && !ctl_drive, "R8 handover",
                      {step_reset, rom_ce_n, ctl_drive}, 3'b100);
                rel_stage = 3;
            end else if (rel_stage == 3) begin
                check(!step_reset && done, "R9 done after step reset",
                      {step_reset, done}, 2'b01);
                rel_stage = 0;
            end
            if (step_reset) sr_cnt++;
            if (ctl_drive && mar_in) begin
                check(!ram_in && bus_drive, "R6 address strobe", {ram_in, bus_drive}, 2'b01);
                check(bus_data == exp_addr[7:0], "R3 R5 address on bus", bus_data, exp_addr);
                mar_model = bus_data;
                mar_cnt++;
            end
            if (ctl_drive && ram_in) begin
                check(prev_mar && !mar_in && bus_drive, "R4 data after address",
                      {prev_mar, mar_in, bus_drive}, 3'b101);
                ram_model[mar_model] = bus_data;
                ram_cnt++;
                exp_addr++;
                if (ram_cnt == exp_len) rel_stage = 1;
            end
            prev_mar = ctl_drive && mar_in;
        end
    end

    // R2: outputs held through each high phase of the CPU clock.
    always @(negedge cpu_clk) begin
        if (rst_n && mar_cnt > 0)
            check(snap == {bus_data, bus_drive, mar_in, ram_in, ctl_drive}, "R2 stable high phase",
                  {bus_data, bus_drive, mar_in, ram_in, ctl_drive}, snap);
    end

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_last = 1'b0;
        mar_cnt = 0; ram_cnt = 0; sr_cnt = 0; exp_addr = 0; rel_stage = 0;
        prev_mar = 0; mar_model = '0;
        for (int i = 0; i < 256; i++) ram_model[i] = 8'h00;
        repeat (10) @(negedge clk);
        check(rom_ce_n && ctl_drive && !bus_drive && !mar_in && !ram_in && !step_reset &&
              !done && in_ready, "R1 in reset",
              {rom_ce_n, ctl_drive, bus_drive, mar_in, ram_in, step_reset, done, in_ready},
              8'b11000001);
        rst_n = 1'b1;
        @(negedge clk);
        check(rom_ce_n && ctl_drive && !bus_drive && !done && in_ready, "R1 after reset",
              {rom_ce_n, ctl_drive, bus_drive, done, in_ready}, 5'b11001);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic last);
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        in_valid = 1'b1;
        in_data = b;
        in_last = last;
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        check(!in_ready, "R10 busy after accept", in_ready, 0);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        // Table-driven load ended by the last flag.
        do_reset();
        exp_len = NV;
        for (int i = 0; i < NV; i++) send_byte(VEC[i][7:0], VEC[i][8]);
        wait_done();
        for (int i = 0; i < NV; i++)
            check(ram_model[i] == VEC[i][7:0], "R4 R5 RAM content", ram_model[i], VEC[i][7:0]);
        check(mar_cnt == NV && ram_cnt == NV, "R5 write count", ram_cnt, NV);
        check(sr_cnt == 1, "R8 step reset single cycle", sr_cnt, 1);
        check(done && !in_ready && !rom_ce_n && !ctl_drive, "R9 final state",
              {done, in_ready, rom_ce_n, ctl_drive}, 4'b1000);

        // R9: input after done is ignored.
        in_valid = 1'b1;
        in_data = 8'h99;
        in_last = 1'b1;
        repeat (320) @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        check(mar_cnt == NV && ram_cnt == NV, "R9 ignored input", ram_cnt, NV);
        check(!bus_drive && !ctl_drive && done && !in_ready, "R9 lines stay released",
              {bus_drive, ctl_drive, done, in_ready}, 4'b0010);

        // R7: full address range, no last flag; ends at address 255.
        do_reset();
        exp_len = 256;
        for (int i = 0; i < 256; i++) send_byte(8'(i) ^ 8'h5A, 1'b0);
        wait_done();
        for (int i = 0; i < 256; i += 17)
            check(ram_model[i] == (8'(i) ^ 8'h5A), "R5 full range content", ram_model[i], 8'(i) ^ 8'h5A);
        check(ram_model[255] == 8'hA5, "R7 top address written", ram_model[255], 8'hA5);
        check(ram_cnt == 256 && done && sr_cnt == 1, "R7 stop at 255", ram_cnt, 256);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule